// File: doc/BRIEF.md
# Parallel DAC Write-and-Load Sequencer

This block is a clocked host-side controller for a dual-channel, double-buffered digital-to-analog converter with a parallel data bus. A request carries an operation mode, a channel and one or two data words. The block turns each request into pin activity on registered outputs: an active-low chip select, a channel address, the data bus, two active-low load strobes and an active-low converter reset. Every window is counted in clock cycles. These windows are the chip-select pulse width, the address and data setup and hold around the rising chip-select edge, the gap between a write and a load, the load pulse width, the hold after a load, and the reset pulse width.

Each timing value is given as a parameter in nanoseconds together with the clock period. The block rounds each value up to whole cycles and uses at least one cycle for every window. Four modes are supported. The first writes one input register only. The second writes one register and then loads that channel. The third writes channel A, then channel B, and then pulses both load strobes together. The fourth only pulses the converter reset. The requester uses a valid/ready handshake, and the block takes no new request until the whole sequence, including its trailing holds, has finished. A shutdown request input is passed to an active-low shutdown pin through a register and does not depend on any sequence.

Top module: `dac_wr_seq`

## Requirements
- R1: After reset, cs_n_o, ld_a_n_o, ld_b_n_o and rst_n_o are high, ab_o and bus_o are zero, req_ready_o is high and busy_o is low.
- R2: In every write, cs_n_o is low for exactly CSW cycles, where CSW = max(1, ceil(CS_NS/CLK_NS), ceil(AS_NS/CLK_NS), ceil(DS_NS/CLK_NS)). This covers the pulse width and both setup windows before the rising edge.
- R3: ab_o and bus_o take their new values on the same edge where cs_n_o falls. They stay unchanged while cs_n_o is low and for at least GAPW = max(1, ceil(AH_NS/CLK_NS), ceil(DH_NS/CLK_NS)) cycles after it rises. Between sequences bus_o keeps its last value.
- R4: For mode 1 (write then load), the strobe of the addressed channel falls exactly GAPL = max(1, ceil(AH_NS/CLK_NS), ceil(DH_NS/CLK_NS), ceil(LS_NS/CLK_NS)) cycles after cs_n_o rises and stays low for LDW = max(1, ceil(LW_NS/CLK_NS)) cycles. The other strobe stays high. Mode 0 (write only) pulses no strobe.
- R5: For mode 2 (pair), channel A is written first with ab_o=1 and bus_o=req_data_i. GAPW cycles after that chip select rises, channel B is written with ab_o=0 and bus_o=req_data_b_i. Both strobes then fall on the same edge, GAPL cycles after the second rise, and stay low for LDW cycles.
- R6: A request is taken on a rising edge where req_valid_i and req_ready_o are both high. req_ready_o is low from the following edge until the sequence ends. For a load sequence it returns LHW = max(1, ceil(LH_NS/CLK_NS)) cycles after the strobes rise; for write only it returns GAPW cycles after cs_n_o rises. Requests presented while req_ready_o is low have no effect. busy_o is always the inverse of req_ready_o.
- R7: For mode 3, rst_n_o is low for exactly RSW = max(1, ceil(RS_NS/CLK_NS)) cycles, and cs_n_o and both strobes stay high.
- R8: ab_o is 1 for channel A and 0 for channel B. req_chan_i uses the same encoding. The mode codes on req_mode_i are 0 = write, 1 = write then load, 2 = pair, 3 = reset pulse.
- R9: shdn_n_o equals the inverse of sleep_i as sampled on the previous rising edge, whatever sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be taken |
| req_mode_i | input | 2 | 0 write, 1 write+load, 2 pair, 3 reset pulse |
| req_chan_i | input | 1 | 1 = channel A, 0 = channel B |
| req_data_i | input | DATA_W | Data word (channel A word in pair mode) |
| req_data_b_i | input | DATA_W | Channel B word in pair mode |
| sleep_i | input | 1 | Shutdown request level |
| busy_o | output | 1 | Sequence in progress |
| cs_n_o | output | 1 | Chip select, active low |
| ab_o | output | 1 | Channel address |
| bus_o | output | DATA_W | Parallel data bus |
| ld_a_n_o | output | 1 | Channel A load strobe, active low |
| ld_b_n_o | output | 1 | Channel B load strobe, active low |
| rst_n_o | output | 1 | Converter reset, active low |
| shdn_n_o | output | 1 | Converter shutdown, active low |

## Verification
The sweep runs every mode on both channels with data words of all zeros, all ones, two alternating patterns and a walking one. Each run is compared cycle by cycle against the expected pin timeline. The walking one shows up a swapped or stuck bus bit. Running both channels separates the address encoding from the choice of load strobe. In pair mode, the distinct A and B words show whether the two writes are ordered correctly and whether the bus changes too early. Some runs keep req_valid_i high with a changing payload for the whole sequence, to show that a busy block ignores requests. Reset pulses and shutdown toggles in the middle of a sequence show that the reset and shutdown pins do not disturb the write and load timing.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  typedef enum logic [1:0] {
    M_WRITE = 2'd0,
    M_WLOAD = 2'd1,
    M_PAIR  = 2'd2,
    M_RESET = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CS,
    PH_GAP,
    PH_LD,
    PH_LH,
    PH_RST
  } phase_e;

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dac_seq_timer.sv
module dac_seq_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
  import dac_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned CSW    = 5,
  parameter int unsigned GAPW   = 2,
  parameter int unsigned GAPL   = 2,
  parameter int unsigned LDW    = 3,
  parameter int unsigned LHW    = 1,
  parameter int unsigned RSW    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_mode_i,
  input  logic              req_chan_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic [DATA_W-1:0] req_data_b_i,
  input  logic              t_zero_i,
  output logic              t_load_o,
  output logic [CNT_W-1:0]  t_val_o,
  output logic              ready_o,
  output logic              cs_n_o,
  output logic              ab_o,
  output logic [DATA_W-1:0] bus_o,
  output logic              ld_a_n_o,
  output logic              ld_b_n_o,
  output logic              rst_n_o
);
  localparam logic [CNT_W-1:0] CSW_V  = CNT_W'(CSW - 1);
  localparam logic [CNT_W-1:0] GAPW_V = CNT_W'(GAPW - 1);
  localparam logic [CNT_W-1:0] GAPL_V = CNT_W'(GAPL - 1);
  localparam logic [CNT_W-1:0] LDW_V  = CNT_W'(LDW - 1);
  localparam logic [CNT_W-1:0] LHW_V  = CNT_W'(LHW - 1);
  localparam logic [CNT_W-1:0] RSW_V  = CNT_W'(RSW - 1);

  phase_e            phase_q;
  mode_e             mode_q;
  logic              chan_q, second_q;
  logic [DATA_W-1:0] data_b_q;
  logic              accept, load_next, pair_first;

  assign ready_o    = (phase_q == PH_IDLE);
  assign accept     = req_valid_i && ready_o;
  assign load_next  = (mode_q == M_WLOAD) || ((mode_q == M_PAIR) && second_q);
  assign pair_first = (mode_q == M_PAIR) && !second_q;

  always_comb begin
    t_load_o = 1'b0;
    t_val_o  = '0;
    unique case (phase_q)
      PH_IDLE: if (accept) begin
        t_load_o = 1'b1;
        t_val_o  = (mode_e'(req_mode_i) == M_RESET) ? RSW_V : CSW_V;
      end
      PH_CS: if (t_zero_i) begin
        t_load_o = 1'b1;
        t_val_o  = load_next ? GAPL_V : GAPW_V;
      end
      PH_GAP: if (t_zero_i) begin
        t_load_o = pair_first || load_next;
        t_val_o  = pair_first ? CSW_V : LDW_V;
      end
      PH_LD: if (t_zero_i) begin
        t_load_o = 1'b1;
        t_val_o  = LHW_V;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      mode_q   <= M_WRITE;
      chan_q   <= 1'b0;
      second_q <= 1'b0;
      data_b_q <= '0;
      cs_n_o   <= 1'b1;
      ab_o     <= 1'b0;
      bus_o    <= '0;
      ld_a_n_o <= 1'b1;
      ld_b_n_o <= 1'b1;
      rst_n_o  <= 1'b1;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (accept) begin
          mode_q   <= mode_e'(req_mode_i);
          chan_q   <= req_chan_i;
          data_b_q <= req_data_b_i;
          second_q <= 1'b0;
          if (mode_e'(req_mode_i) == M_RESET) begin
            rst_n_o <= 1'b0;
            phase_q <= PH_RST;
          end else begin
            cs_n_o  <= 1'b0;
            ab_o    <= (mode_e'(req_mode_i) == M_PAIR) ? 1'b1 : req_chan_i;
            bus_o   <= req_data_i;
            phase_q <= PH_CS;
          end
        end
        PH_CS: if (t_zero_i) begin
          cs_n_o  <= 1'b1;
          phase_q <= PH_GAP;
        end
        PH_GAP: if (t_zero_i) begin
          if (pair_first) begin
            second_q <= 1'b1;
            cs_n_o   <= 1'b0;
            ab_o     <= 1'b0;
            bus_o    <= data_b_q;
            phase_q  <= PH_CS;
          end else if (load_next) begin
            ld_a_n_o <= !((mode_q == M_PAIR) || chan_q);
            ld_b_n_o <= !((mode_q == M_PAIR) || !chan_q);
            phase_q  <= PH_LD;
          end else begin
            phase_q  <= PH_IDLE;
          end
        end
        PH_LD: if (t_zero_i) begin
          ld_a_n_o <= 1'b1;
          ld_b_n_o <= 1'b1;
          phase_q  <= PH_LH;
        end
        PH_LH: if (t_zero_i) phase_q <= PH_IDLE;
        PH_RST: if (t_zero_i) begin
          rst_n_o <= 1'b1;
          phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
  import dac_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CLK_NS = 10,
  parameter int unsigned CS_NS  = 45,
  parameter int unsigned AS_NS  = 30,
  parameter int unsigned AH_NS  = 0,
  parameter int unsigned DS_NS  = 30,
  parameter int unsigned DH_NS  = 20,
  parameter int unsigned LS_NS  = 20,
  parameter int unsigned LW_NS  = 30,
  parameter int unsigned LH_NS  = 10,
  parameter int unsigned RS_NS  = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_mode_i,
  input  logic              req_chan_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic [DATA_W-1:0] req_data_b_i,
  input  logic              sleep_i,
  output logic              busy_o,
  output logic              cs_n_o,
  output logic              ab_o,
  output logic [DATA_W-1:0] bus_o,
  output logic              ld_a_n_o,
  output logic              ld_b_n_o,
  output logic              rst_n_o,
  output logic              shdn_n_o
);
  localparam int unsigned CSW  = max2(ns2cyc(CS_NS, CLK_NS),
                                      max2(ns2cyc(AS_NS, CLK_NS), ns2cyc(DS_NS, CLK_NS)));
  localparam int unsigned GAPW = max2(ns2cyc(AH_NS, CLK_NS), ns2cyc(DH_NS, CLK_NS));
  localparam int unsigned GAPL = max2(GAPW, ns2cyc(LS_NS, CLK_NS));
  localparam int unsigned LDW  = ns2cyc(LW_NS, CLK_NS);
  localparam int unsigned LHW  = ns2cyc(LH_NS, CLK_NS);
  localparam int unsigned RSW  = ns2cyc(RS_NS, CLK_NS);
  localparam int unsigned MAXC = max2(max2(CSW, GAPL), max2(max2(LDW, LHW), RSW));
  localparam int unsigned CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);

  logic             t_load, t_zero;
  logic [CNT_W-1:0] t_val;

  dac_seq_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i, .rst_ni, .load_i(t_load), .val_i(t_val), .zero_o(t_zero)
  );

  dac_seq_ctrl #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .CSW(CSW), .GAPW(GAPW), .GAPL(GAPL),
    .LDW(LDW), .LHW(LHW), .RSW(RSW)
  ) i_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_mode_i, .req_chan_i, .req_data_i,
    .req_data_b_i, .t_zero_i(t_zero), .t_load_o(t_load), .t_val_o(t_val),
    .ready_o(req_ready_o), .cs_n_o, .ab_o, .bus_o, .ld_a_n_o, .ld_b_n_o, .rst_n_o
  );

  assign busy_o = !req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shdn_n_o <= 1'b1;
    else         shdn_n_o <= !sleep_i;
  end
endmodule

// File: rtl/dac_wr_seq_chk.sv
module dac_wr_seq_chk #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CSW    = 5,
  parameter int unsigned LDW    = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              sleep_i,
  input logic              cs_n_o,
  input logic              ab_o,
  input logic [DATA_W-1:0] bus_o,
  input logic              ld_a_n_o,
  input logic              ld_b_n_o,
  input logic              rst_n_o,
  input logic              shdn_n_o
);
  logic [7:0] cs_cnt, ld_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_cnt <= '0;
      ld_cnt <= '0;
    end else begin
      cs_cnt <= cs_n_o ? 8'd0 : ((cs_cnt == 8'hff) ? cs_cnt : cs_cnt + 8'd1);
      ld_cnt <= ld_a_n_o ? 8'd0 : ((ld_cnt == 8'hff) ? ld_cnt : ld_cnt + 8'd1);
    end
  end

  // R2
  cs_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |-> (cs_cnt == 8'(CSW)));

  // R3
  bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && $past(!cs_n_o)) |-> ($stable(bus_o) && $stable(ab_o)));

  // R4
  ld_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ld_a_n_o) |-> (ld_cnt == 8'(LDW)));

  // R4
  ld_vs_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_a_n_o || !ld_b_n_o) |-> cs_n_o);

  // R6
  busy_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o || !ld_a_n_o || !ld_b_n_o || !rst_n_o) |-> !req_ready_o);

  // R7
  rst_alone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_n_o |-> (cs_n_o && ld_a_n_o && ld_b_n_o));

  // R9
  shdn_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(sleep_i) |=> (shdn_n_o == !$past(sleep_i)));
endmodule

bind dac_wr_seq dac_wr_seq_chk #(.DATA_W(DATA_W), .CSW(CSW), .LDW(LDW)) i_chk (
  .clk_i, .rst_ni, .req_ready_o, .sleep_i, .cs_n_o, .ab_o, .bus_o,
  .ld_a_n_o, .ld_b_n_o, .rst_n_o, .shdn_n_o
);

// File: tb/test_dac_wr_seq.sv
module test_dac_wr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  // spec timing at 10 ns clock
  localparam int CSW  = 5;  // max(ceil45,ceil30,ceil30)/10
  localparam int GAPW = 2;  // max(1,0,ceil20/10)
  localparam int GAPL = 2;  // max(GAPW, 20/10)
  localparam int LDW  = 3;
  localparam int LHW  = 1;
  localparam int RSW  = 4;
  localparam int NS   = 64;

  logic clk = 0, rst_n = 0;
  logic valid = 0, chan = 0, sleep = 0;
  logic [1:0] mode = 0;
  logic [DW-1:0] da = 0, db = 0;
  logic ready, busy, cs_n, ab, ld_a_n, ld_b_n, rs_n, shdn_n;
  logic [DW-1:0] bus;

  int n_chk = 0, n_bad = 0;
  logic prev_ab = 0;
  logic [DW-1:0] prev_bus = 0;
  logic e_cs[NS], e_la[NS], e_lb[NS], e_rs[NS], e_rdy[NS], e_ab[NS];
  logic [DW-1:0] e_bus[NS];
  logic g_cs[NS], g_la[NS], g_lb[NS], g_rs[NS], g_rdy[NS], g_ab[NS];
  logic [DW-1:0] g_bus[NS];
  int n_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_wr_seq i_dac_wr_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_mode_i(mode), .req_chan_i(chan), .req_data_i(da), .req_data_b_i(db),
    .sleep_i(sleep), .busy_o(busy), .cs_n_o(cs_n), .ab_o(ab), .bus_o(bus),
    .ld_a_n_o(ld_a_n), .ld_b_n_o(ld_b_n), .rst_n_o(rs_n), .shdn_n_o(shdn_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic put_write(inout int t, input logic a, input logic [DW-1:0] d, input int gap);
    for (int k = t; k < NS; k++) begin e_ab[k] = a; e_bus[k] = d; end
    for (int k = t; k < t + CSW; k++) e_cs[k] = 0;
    t = t + CSW + gap;
  endtask

  task automatic build(input logic [1:0] m, input logic c, input logic [DW-1:0] x,
                       input logic [DW-1:0] y);
    int t = 0;
    for (int k = 0; k < NS; k++) begin
      e_cs[k] = 1; e_la[k] = 1; e_lb[k] = 1; e_rs[k] = 1; e_rdy[k] = 1;
      e_ab[k] = prev_ab; e_bus[k] = prev_bus;
    end
    if (m == 2'd3) begin
      for (int k = 0; k < RSW; k++) e_rs[k] = 0;
      t = RSW;
    end else begin
      if (m == 2'd2) begin
        put_write(t, 1'b1, x, GAPW);
        put_write(t, 1'b0, y, GAPL);
      end else begin
        put_write(t, c, x, (m == 2'd1) ? GAPL : GAPW);
      end
      if (m != 2'd0) begin
        for (int k = t; k < t + LDW; k++) begin
          if (m == 2'd2 || c)  e_la[k] = 0;
          if (m == 2'd2 || !c) e_lb[k] = 0;
        end
        t = t + LDW + LHW;
      end
    end
    for (int k = 0; k < t; k++) e_rdy[k] = 0;
    n_exp = t;
    prev_ab = e_ab[NS-1];
    prev_bus = e_bus[NS-1];
  endtask

  task automatic cmp_bit(input string req, input string nm, ref logic g[NS], ref logic e[NS]);
    int bad = -1;
    for (int k = 0; k < n_exp + 2; k++) if (g[k] !== e[k] && bad < 0) bad = k;
    check(bad < 0, req, $sformatf("%s at sample %0d", nm, bad),
          (bad < 0) ? 0 : longint'(g[bad]), (bad < 0) ? 0 : longint'(e[bad]));
  endtask

  task automatic run(input logic [1:0] m, input logic c, input logic [DW-1:0] x,
                     input logic [DW-1:0] y, input bit pester);
    string rq;
    build(m, c, x, y);
    @(negedge clk);
    valid = 1; mode = m; chan = c; da = x; db = y;
    @(posedge clk);
    for (int k = 0; k < n_exp + 2; k++) begin
      @(negedge clk);
      g_cs[k] = cs_n; g_la[k] = ld_a_n; g_lb[k] = ld_b_n; g_rs[k] = rs_n;
      g_rdy[k] = ready; g_ab[k] = ab; g_bus[k] = bus;
      if (busy !== !ready) check(0, "R6", "busy_o vs ready", busy, !ready);
      if (pester && !ready) begin
        valid = 1; mode = 2'(k); chan = ~c; da = ~x; db = ~y;
      end else valid = 0;
    end
    rq = (m == 2'd2) ? "R5" : "R4";
    cmp_bit("R2", "cs_n_o", g_cs, e_cs);
    cmp_bit("R8", "ab_o", g_ab, e_ab);
    cmp_bit(rq, "ld_a_n_o", g_la, e_la);
    cmp_bit(rq, "ld_b_n_o", g_lb, e_lb);
    cmp_bit("R7", "rst_n_o", g_rs, e_rs);
    cmp_bit(pester ? "R6 busy-ignore" : "R6", "req_ready_o", g_rdy, e_rdy);
    begin
      int bad = -1;
      for (int k = 0; k < n_exp + 2; k++) if (g_bus[k] !== e_bus[k] && bad < 0) bad = k;
      check(bad < 0, (m == 2'd2) ? "R5" : "R3", $sformatf("bus_o at sample %0d", bad),
            (bad < 0) ? 0 : longint'(g_bus[bad]), (bad < 0) ? 0 : longint'(e_bus[bad]));
    end
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] pats[6];
    pats[0] = '0; pats[1] = '1; pats[2] = 12'haaa; pats[3] = 12'h555;
    pats[4] = 12'h001; pats[5] = 12'h800;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cs_n === 1 && ld_a_n === 1 && ld_b_n === 1 && rs_n === 1, "R1", "strobes",
          {cs_n, ld_a_n, ld_b_n, rs_n}, 4'hf);
    check(ab === 0 && bus === 0, "R1", "ab/bus", {ab, bus}, 0);
    check(ready === 1 && busy === 0, "R1", "ready/busy", {ready, busy}, 2'b10);
    rst_n = 1;
    @(negedge clk);
    check(ready === 1 && cs_n === 1, "R1", "idle after release", {ready, cs_n}, 2'b11);

    for (int m = 0; m < 3; m++)
      for (int c = 0; c < 2; c++)
        for (int p = 0; p < 6; p++)
          run(2'(m), c[0], pats[p], pats[(p + 3) % 6], (p % 2) == 1);
    for (int b = 0; b < DW; b++) run(2'd2, 1'b0, DW'(1) << b, ~(DW'(1) << b), 1'b0);
    for (int b = 0; b < DW; b++) run(2'd1, b[0], DW'(1) << b, '0, 1'b0);
    run(2'd3, 1'b0, 12'h123, 12'h456, 1'b0);
    run(2'd3, 1'b1, 12'h321, 12'h654, 1'b1);
    run(2'd0, 1'b1, 12'h3c3, 12'h000, 1'b0);

    // R9 shutdown tracks sleep, sequence unaffected
    @(negedge clk); sleep = 1;
    @(negedge clk);
    check(shdn_n === 0, "R9", "shdn_n_o after sleep=1", shdn_n, 0);
    run(2'd2, 1'b0, 12'h5a5, 12'ha5a, 1'b0);
    check(shdn_n === 0, "R9", "shdn_n_o held during pair", shdn_n, 0);
    sleep = 0;
    @(negedge clk);
    check(shdn_n === 1, "R9", "shdn_n_o after sleep=0", shdn_n, 1);
    run(2'd1, 1'b1, 12'hfed, 12'h000, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule